// File: doc/BRIEF.md
# Multiplexed backplane channel demultiplexer

The block takes one high-speed serial stream that carries eight T1 or E1 channels and splits it into per-channel payload bytes. The stream is sampled on every rising edge of its own high-speed clock. A frame-sync pulse marks the first bit of the frame. Three interleave schemes are supported. Two are bit-interleaved: one at 12.352 MHz, which carries only T1 channels, and one at 16.384 MHz. The third is byte-interleaved at 16.384 MHz. In the 16.384 MHz schemes a T1 channel sits inside a 32-slot frame shaped like an E1 frame, and one slot position in every four carries no payload.

Each completed payload byte leaves the block with its channel number, its timeslot number and a single-cycle strobe. The per-channel framer that follows uses these to rebuild its own 24-slot or 32-slot frame. The interleave scheme and the T1 flag are taken on the frame-sync pulse, so a host can reprogram them at any time without tearing a frame.

Top module: `hsbp_chan_demux`

## Requirements
- R1: `mode_i` selects the scheme: 0 is bit-interleaved T1 at 12.352 MHz with a frame of 1544 positions; 1 is bit-interleaved at 16.384 MHz with a frame of 2048 positions; 2 and 3 are byte-interleaved at 16.384 MHz with a frame of 2048 positions.
- R2: In bit-interleaved mode, position p of the frame belongs to channel p mod 8, is bit (p/8) mod 8 of that channel's byte counted most significant bit first, and lies in raw slot p/64.
- R3: In byte-interleaved mode, eight consecutive positions form one byte, most significant bit first, of channel (p/8) mod 8 in raw slot p/64.
- R4: In mode 0 the raw slots 0 to 23 are the T1 timeslots. The last eight positions, 1536 to 1543, are discarded. `t1_i` has no effect in this mode.
- R5: In modes 1 to 3 with `t1_i`=1, a raw slot s with s mod 4 = 0 is dropped. Every other slot becomes T1 timeslot 3*(s/4) + (s mod 4) - 1, which gives 0 to 23 in order.
- R6: A completed byte appears on `byte_o`, `chan_o` and `slot_o`, with `valid_o` high for one clock, on the clock edge that samples its last bit. Each full frame gives exactly one byte for each channel and timeslot pair: 192 bytes for T1 and 256 for E1.
- R7: A high `sync_i` makes the bit sampled with it position 0, including in the middle of a frame.
- R8: `mode_i` and `t1_i` are sampled only together with `sync_i`. Changes between pulses have no effect on the output until the next pulse.
- R9: After reset the outputs are zero. `valid_o` stays low until the first `sync_i` pulse.
- R10: Without a new pulse, the position counter wraps at the end of the frame and the next frame is split the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | High-speed stream clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame-sync pulse, high with position 0 |
| data_i | input | 1 | Multiplexed serial data |
| mode_i | input | 2 | Interleave scheme, taken at sync |
| t1_i | input | 1 | T1 payload in a 16.384 MHz frame, taken at sync |
| byte_o | output | 8 | Completed payload byte |
| chan_o | output | 3 | Channel of `byte_o` |
| slot_o | output | 5 | Timeslot of `byte_o` |
| valid_o | output | 1 | Single-cycle strobe for the byte fields |

## Verification
If the position counter slips, or the wrong interleave decode is chosen, bytes are tagged with the wrong channel or timeslot. Their contents stop matching the pattern the bench expects for that pair, so the first wrong byte shows the fault within one slot time. A wrong skip rule or a wrong frame length shows up at the end of the same frame as a missing or repeated channel and timeslot pair, or as a wrong byte count. A mode that leaks in between sync pulses corrupts the very next byte.

// File: rtl/hsbp_pkg.sv
package hsbp_pkg;
  localparam int unsigned NUM_CH      = 8;
  localparam int unsigned SLOT_BITS   = 8;
  localparam int unsigned E1_SLOTS    = 32;
  localparam int unsigned T1_SLOTS    = 24;
  localparam int unsigned SKIP_EVERY  = 4;

  localparam int unsigned CH_W        = $clog2(NUM_CH);
  localparam int unsigned BIT_W       = $clog2(SLOT_BITS);
  localparam int unsigned SLOT_W      = $clog2(E1_SLOTS);
  localparam int unsigned E1_FRAME    = NUM_CH * SLOT_BITS * E1_SLOTS;
  localparam int unsigned T1_PAYLOAD  = NUM_CH * SLOT_BITS * T1_SLOTS;
  localparam int unsigned T1_FRAME    = T1_PAYLOAD + NUM_CH;
  localparam int unsigned POS_W       = $clog2(E1_FRAME);

  typedef enum logic [1:0] {
    IL_BIT_T1    = 2'd0,
    IL_BIT_HS    = 2'd1,
    IL_BYTE_HS   = 2'd2,
    IL_BYTE_HS_B = 2'd3
  } il_mode_e;
endpackage

// File: rtl/hsbp_frame_timer.sv
module hsbp_frame_timer
  import hsbp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  il_mode_e         mode_i,
  input  logic             t1_i,
  output logic             locked_o,
  output logic [POS_W-1:0] pos_o,
  output il_mode_e         mode_o,
  output logic             t1_o,
  output logic             frame_t1_o
);
  il_mode_e         mode_q;
  logic             t1_q;
  logic             locked_q;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] last_pos;

  // configuration and position seen by the bit sampled this cycle
  always_comb begin
    mode_o   = sync_i ? mode_i : mode_q;
    t1_o     = sync_i ? t1_i   : t1_q;
    pos_o    = sync_i ? '0     : pos_q;
    locked_o = locked_q | sync_i;
    last_pos = (mode_o == IL_BIT_T1) ? POS_W'(T1_FRAME - 1) : POS_W'(E1_FRAME - 1);
  end

  assign frame_t1_o = (mode_q == IL_BIT_T1) || t1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= IL_BIT_HS;
      t1_q     <= 1'b0;
      locked_q <= 1'b0;
      pos_q    <= '0;
    end else begin
      if (sync_i) begin
        mode_q <= mode_i;
        t1_q   <= t1_i;
      end
      locked_q <= locked_o;
      pos_q    <= (pos_o == last_pos) ? '0 : pos_o + 1'b1;
    end
  end

  assert_sync_reload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (pos_q == POS_W'(1)));

  assert_mode_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> ($stable(mode_q) && $stable(t1_q)));

  assert_t1_frame_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == IL_BIT_T1) |-> (pos_q < POS_W'(T1_FRAME)));
endmodule

// File: rtl/hsbp_pos_decode.sv
module hsbp_pos_decode
  import hsbp_pkg::*;
(
  input  logic [POS_W-1:0]  pos_i,
  input  il_mode_e          mode_i,
  input  logic              t1_i,
  output logic [CH_W-1:0]   ch_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              keep_o
);
  localparam int unsigned SLOT_LSB = CH_W + BIT_W;
  localparam int unsigned GRP_SH   = $clog2(SKIP_EVERY);

  logic [SLOT_W-1:0]        raw;
  logic [SLOT_W-GRP_SH-1:0] grp;
  logic [GRP_SH-1:0]        sub;
  logic [SLOT_W-1:0]        packed_slot;
  logic                     byte_il;

  always_comb begin
    raw         = pos_i[SLOT_LSB +: SLOT_W];
    grp         = raw[SLOT_W-1:GRP_SH];
    sub         = raw[GRP_SH-1:0];
    packed_slot = SLOT_W'(int'(grp) * int'(SKIP_EVERY - 1) + int'(sub) - 1);
    byte_il     = (mode_i == IL_BYTE_HS) || (mode_i == IL_BYTE_HS_B);

    if (byte_il) begin
      bit_o = pos_i[BIT_W-1:0];
      ch_o  = pos_i[BIT_W +: CH_W];
    end else begin
      ch_o  = pos_i[CH_W-1:0];
      bit_o = pos_i[CH_W +: BIT_W];
    end

    if (mode_i == IL_BIT_T1) begin
      keep_o = pos_i < POS_W'(T1_PAYLOAD);  // trailing per-channel bit dropped
      slot_o = raw;
    end else if (t1_i) begin
      keep_o = (sub != '0);
      slot_o = packed_slot;
    end else begin
      keep_o = 1'b1;
      slot_o = raw;
    end
  end
endmodule

// File: rtl/hsbp_lane_bank.sv
module hsbp_lane_bank
  import hsbp_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 shift_i,
  input  logic [CH_W-1:0]      ch_i,
  input  logic                 d_i,
  output logic [SLOT_BITS-2:0] word_o
);
  logic [SLOT_BITS-2:0] lane_w [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    logic [SLOT_BITS-2:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              sh_q <= '0;
      else if (shift_i && (ch_i == CH_W'(g)))   sh_q <= {sh_q[SLOT_BITS-3:0], d_i};
    end
    assign lane_w[g] = sh_q;
  end

  assign word_o = lane_w[ch_i];
endmodule

// File: rtl/hsbp_chan_demux.sv
module hsbp_chan_demux
  import hsbp_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sync_i,
  input  logic                 data_i,
  input  logic [1:0]           mode_i,
  input  logic                 t1_i,
  output logic [SLOT_BITS-1:0] byte_o,
  output logic [CH_W-1:0]      chan_o,
  output logic [SLOT_W-1:0]    slot_o,
  output logic                 valid_o
);
  logic                 locked;
  logic [POS_W-1:0]     pos;
  il_mode_e             act_mode;
  logic                 act_t1;
  logic                 frame_t1;
  logic [CH_W-1:0]      ch;
  logic [BIT_W-1:0]     bit_idx;
  logic [SLOT_W-1:0]    slot;
  logic                 keep;
  logic                 shift;
  logic                 complete;
  logic [SLOT_BITS-2:0] word;

  hsbp_frame_timer u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_i),
    .mode_i     (il_mode_e'(mode_i)),
    .t1_i       (t1_i),
    .locked_o   (locked),
    .pos_o      (pos),
    .mode_o     (act_mode),
    .t1_o       (act_t1),
    .frame_t1_o (frame_t1)
  );

  hsbp_pos_decode u_decode (
    .pos_i  (pos),
    .mode_i (act_mode),
    .t1_i   (act_t1),
    .ch_o   (ch),
    .bit_o  (bit_idx),
    .slot_o (slot),
    .keep_o (keep)
  );

  assign shift    = locked && keep;
  assign complete = shift && (bit_idx == BIT_W'(SLOT_BITS - 1));

  hsbp_lane_bank u_lanes (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .ch_i    (ch),
    .d_i     (data_i),
    .word_o  (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      byte_o  <= '0;
      chan_o  <= '0;
      slot_o  <= '0;
    end else begin
      valid_o <= complete;
      if (complete) begin
        byte_o <= {word, data_i};
        chan_o <= ch;
        slot_o <= slot;
      end
    end
  end

  assert_no_early_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked |=> !valid_o);

  assert_t1_slot_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && frame_t1) |-> (slot_o < SLOT_W'(T1_SLOTS)));
endmodule

// File: tb/hsbp_chan_demux_test.sv
module hsbp_chan_demux_test;
  localparam int CLK_PERIOD = 10;

  // {no_sync, mode[1:0], t1, seed[7:0]}; no_sync frames rely on wrap (R10)
  localparam int NVEC = 8;
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 1'b0, 8'h11},
    {1'b1, 2'd0, 1'b0, 8'h12},
    {1'b0, 2'd1, 1'b0, 8'h23},
    {1'b0, 2'd1, 1'b1, 8'h34},
    {1'b0, 2'd2, 1'b0, 8'h45},
    {1'b1, 2'd2, 1'b0, 8'h56},
    {1'b0, 2'd3, 1'b1, 8'h67},
    {1'b0, 2'd0, 1'b1, 8'h78}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sync_i = 1'b0;
  logic       data_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic       t1_i = 1'b0;
  logic [7:0] byte_o;
  logic [2:0] chan_o;
  logic [4:0] slot_o;
  logic       valid_o;

  int n_checks = 0;
  int n_fail = 0;
  int cur_mode = 0;
  int cur_t1 = 0;
  int cur_seed = 0;
  int valid_cnt = 0;
  bit seen [256];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  hsbp_chan_demux uut (
    .clk_i, .rst_ni, .sync_i, .data_i, .mode_i, .t1_i,
    .byte_o, .chan_o, .slot_o, .valid_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int ch, input int sl);
    int x;
    x = seed * 29 + ch * 53 + sl * 7 + sl * ch;
    return 8'(x ^ (x >> 8));
  endfunction

  function automatic logic sbit(input int mode, input int t1, input int seed, input int p);
    int ch, b, rs, ts;
    logic [7:0] v;
    if (mode >= 2) begin b = p % 8; ch = (p / 8) % 8; end
    else           begin ch = p % 8; b = (p / 8) % 8; end
    rs = p / 64;
    if (mode == 0) begin
      if (p >= 1536) return 1'b1;
      ts = rs;
    end else if (t1 != 0) begin
      if (rs % 4 == 0) return logic'(p % 2);
      ts = 3 * (rs / 4) + (rs % 4) - 1;
    end else ts = rs;
    v = pat(seed, ch, ts);
    return v[7-b];
  endfunction

  function automatic int flen(input int mode);
    return (mode == 0) ? 1544 : 2048;
  endfunction

  function automatic int ecnt(input int mode, input int t1);
    return (mode == 0 || t1 != 0) ? 192 : 256;
  endfunction

  // per-byte check, one cycle after the last bit (R6)
  always begin
    @(posedge clk_i);
    #1;
    if (valid_o) begin
      int lim;
      string tag;
      bit ok;
      lim = (cur_mode == 0 || cur_t1 != 0) ? 24 : 32;
      tag = (cur_mode == 0) ? "R4" : (cur_t1 != 0) ? "R5" : (cur_mode >= 2) ? "R3" : "R2";
      ok = (int'(slot_o) < lim) && !seen[{chan_o, slot_o}] &&
           (byte_o == pat(cur_seed, chan_o, slot_o));
      chk(ok, tag, int'(byte_o), int'(pat(cur_seed, chan_o, slot_o)));
      seen[{chan_o, slot_o}] = 1'b1;
      valid_cnt++;
    end
  end

  task automatic clear_frame();
    valid_cnt = 0;
    for (int i = 0; i < 256; i++) seen[i] = 1'b0;
  endtask

  // drives n bits; after position 0 the mode/t1 pins switch to alt values
  task automatic drive(input int mode, input int t1, input int seed, input bit do_sync,
                       input int n, input int alt_mode, input int alt_t1);
    for (int p = 0; p < n; p++) begin
      @(negedge clk_i);
      if (p == 0) begin
        cur_mode = mode; cur_t1 = t1; cur_seed = seed;
        mode_i = 2'(mode); t1_i = logic'(t1);
      end else begin
        mode_i = 2'(alt_mode); t1_i = logic'(alt_t1);
      end
      sync_i = do_sync && (p == 0);
      data_i = sbit(mode, t1, seed, p);
    end
    @(posedge clk_i);
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(valid_o == 1'b0 && byte_o == 8'h0 && chan_o == 3'd0 && slot_o == 5'd0,
        "R9", int'(valid_o), 0);
    rst_ni = 1'b1;

    // R9 no output before first sync
    clear_frame();
    cur_mode = 2;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk_i);
      mode_i = 2'd2;
      data_i = logic'(i % 3 == 0);
    end
    @(posedge clk_i); #2;
    chk(valid_cnt == 0, "R9", valid_cnt, 0);

    // table walk: R1, R6, R10
    for (int v = 0; v < NVEC; v++) begin
      int m, t, s;
      bit ns;
      ns = VEC[v][11];
      m  = int'(VEC[v][10:9]);
      t  = int'(VEC[v][8]);
      s  = int'(VEC[v][7:0]);
      clear_frame();
      drive(m, t, s, !ns, flen(m), m, t);
      chk(valid_cnt == ecnt(m, t), ns ? "R10" : "R1 R6", valid_cnt, ecnt(m, t));
    end

    // R8: pins change mid-frame, bit E1 split must hold
    clear_frame();
    drive(1, 0, 8'h9a, 1'b1, 2048, 2, 1);
    chk(valid_cnt == 256, "R8", valid_cnt, 256);
    // R8: next frame without sync still bit E1 despite pins
    clear_frame();
    drive(1, 0, 8'h9b, 1'b0, 2048, 2, 1);
    chk(valid_cnt == 256, "R8", valid_cnt, 256);

    // R7: abort a byte-mode frame and resync mid-frame
    clear_frame();
    drive(2, 0, 8'hc1, 1'b1, 700, 2, 0);
    clear_frame();
    drive(1, 1, 8'hc2, 1'b1, 2048, 1, 1);
    chk(valid_cnt == 192, "R7", valid_cnt, 192);
    clear_frame();
    drive(0, 0, 8'hc3, 1'b1, 1544, 0, 0);
    chk(valid_cnt == 192, "R7", valid_cnt, 192);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule